// File: doc/BRIEF.md
# Exception Entry Sequencer

This block moves a 32-bit processor core into an exception or interrupt handler. It accepts three kinds of request: a software break that carries a trap number, a translation-miss request, and a 32-bit mask of pending hardware interrupt lines. When it accepts a request it computes a vector number and reads the handler address from a table in memory. The table starts at the exception base register, and each entry is one 32-bit word. The block then commits three updates together: the return address, a new status word with the flag context pushed, and the new program counter.

The core's register file gives the block the current program counter, the exception base and the status word. The block writes back the program counter, the return-address register and the status word through separate write strobes. The handler fetch uses a simple read port. The block issues an address and waits for any number of cycles until the memory marks the response valid. Only one entry is in flight at a time.

Top module: `exc_entry_seq`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `done`, `mem_rd_req` and all three write strobes are low. Reset does not drive any architectural register.
- R2: A break request uses `brk_trap` as the vector number. It reads the handler from `ebp_i + 4*brk_trap` and saves `pc_i + 2` as the return address.
- R3: A miss request uses vector number 4, so the read address is `ebp_i + 16`. The saved return address is `pc_i` unchanged.
- R4: A hardware interrupt uses vector number 0x30 plus the index of the highest set bit of `irq_pend`. The saved return address is `pc_i`.
- R5: A hardware interrupt is accepted only when `irq_pend` is non-zero and bit 5 of `ccs_i` (the interrupt-enable flag) is 1. Otherwise the block starts no read, writes nothing and stays idle.
- R6: When requests arrive together, break wins over miss, and miss wins over hardware interrupt.
- R7: The committed status word keeps bits 31:30 of `ccs_i` as sampled at acceptance. Bits 19:0 move up to bits 29:10, and bits 9:0 become zero.
- R8: The cycle after `mem_rd_valid` is seen with `mem_rd_req` high is the commit cycle. In that cycle `done`, `pc_wr_en`, `erp_wr_en` and `ccs_wr_en` are high together for exactly one cycle, and `pc_wr_data` equals the word that was read.
- R9: From the cycle after acceptance, `mem_rd_req` stays high with `mem_rd_addr` held steady until `mem_rd_valid` is seen.
- R10: While `busy` is high, no new request is accepted. A request that is still held waits and is accepted in the first idle cycle after commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_req | input | 1 | Software break request |
| brk_trap | input | 8 | Trap number for a break |
| miss_req | input | 1 | Translation-miss request |
| irq_pend | input | 32 | Pending hardware interrupt lines |
| pc_i | input | 32 | Current program counter |
| ebp_i | input | 32 | Exception vector table base |
| ccs_i | input | 32 | Current status word |
| mem_rd_req | output | 1 | Vector read request |
| mem_rd_addr | output | 32 | Vector read address |
| mem_rd_valid | input | 1 | Read response valid |
| mem_rd_data | input | 32 | Read response data (handler address) |
| pc_wr_en | output | 1 | Program counter write strobe |
| pc_wr_data | output | 32 | New program counter |
| erp_wr_en | output | 1 | Return-address register write strobe |
| erp_wr_data | output | 32 | Saved return address |
| ccs_wr_en | output | 1 | Status word write strobe |
| ccs_wr_data | output | 32 | New status word |
| busy | output | 1 | An entry is in progress |
| done | output | 1 | One-cycle commit pulse |

## Verification
Directed entries of each kind check three things: the table offset, the PC+2 offset that only a break applies, and the vector mapping for the lowest, highest and a middle interrupt line. Requests raised together, and a request held through an entry in progress, separate the priority order from the rule that a busy block accepts nothing new. Interrupts with the enable flag clear, and an empty mask with the flag set, must leave the read port and write strobes quiet. Random mixes of requests, status words and read latencies then compare every committed value with the bench's own formulas.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    parameter int XLEN = 32;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_VREAD  = 2'd1,
        ST_COMMIT = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_BREAK = 2'd1,
        SRC_MISS  = 2'd2,
        SRC_IRQ   = 2'd3
    } entry_src_e;

    typedef struct packed {
        seq_state_e        state;
        logic [XLEN-1:0]   vec_addr;
        logic [XLEN-1:0]   handler;
        logic [XLEN-1:0]   ret_addr;
        logic [XLEN-1:0]   status;
    } seq_regs_t;

endpackage

// File: rtl/exc_msb_find.sv
module exc_msb_find #(
    parameter int W     = 32,
    parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = i[IDX_W-1:0];
            end
        end
    end
endmodule

// File: rtl/exc_req_arbiter.sv
module exc_req_arbiter
    import exc_entry_pkg::*;
#(
    parameter int          TRAP_W   = 8,
    parameter int          IRQ_W    = 32,
    parameter int          VEC_W    = 8,
    parameter logic [7:0]  MISS_VEC = 8'd4,
    parameter logic [7:0]  IRQ_BASE = 8'h30
) (
    input  logic              brk_req,
    input  logic [TRAP_W-1:0] brk_trap,
    input  logic              miss_req,
    input  logic [IRQ_W-1:0]  irq_pend,
    input  logic              irq_enable,
    output logic              take,
    output entry_src_e        src,
    output logic [VEC_W-1:0]  vec_num
);
    localparam int IDX_W = (IRQ_W > 1) ? $clog2(IRQ_W) : 1;

    logic             irq_any;
    logic [IDX_W-1:0] irq_idx;

    exc_msb_find #(.W(IRQ_W), .IDX_W(IDX_W)) u_msb (
        .vec   (irq_pend),
        .found (irq_any),
        .idx   (irq_idx)
    );

    always_comb begin
        take    = 1'b0;
        src     = SRC_NONE;
        vec_num = '0;
        if (brk_req) begin
            take    = 1'b1;
            src     = SRC_BREAK;
            vec_num = VEC_W'(brk_trap);
        end else if (miss_req) begin
            take    = 1'b1;
            src     = SRC_MISS;
            vec_num = VEC_W'(MISS_VEC);
        end else if (irq_any && irq_enable) begin
            take    = 1'b1;
            src     = SRC_IRQ;
            vec_num = VEC_W'(IRQ_BASE) + VEC_W'(irq_idx);
        end
    end
endmodule

// File: rtl/exc_status_stack.sv
module exc_status_stack #(
    parameter int W     = 32,
    parameter int KEEP  = 2,
    parameter int SHIFT = 10
) (
    input  logic [W-1:0] old_status,
    output logic [W-1:0] new_status
);
    localparam int MOVED = W - KEEP - SHIFT;

    generate
        if (MOVED > 0) begin : g_stack
            assign new_status = {old_status[W-1 -: KEEP],
                                 old_status[MOVED-1:0],
                                 {SHIFT{1'b0}}};
        end else begin : g_clear
            assign new_status = {old_status[W-1 -: KEEP], {(W-KEEP){1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int TRAP_W   = 8,
    parameter int IRQ_W    = 32,
    parameter int VEC_W    = 8,
    parameter int IEN_BIT  = 5,
    parameter int BRK_ILEN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              brk_req,
    input  logic [TRAP_W-1:0] brk_trap,
    input  logic              miss_req,
    input  logic [IRQ_W-1:0]  irq_pend,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   ebp_i,
    input  logic [XLEN-1:0]   ccs_i,
    output logic              mem_rd_req,
    output logic [XLEN-1:0]   mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [XLEN-1:0]   mem_rd_data,
    output logic              pc_wr_en,
    output logic [XLEN-1:0]   pc_wr_data,
    output logic              erp_wr_en,
    output logic [XLEN-1:0]   erp_wr_data,
    output logic              ccs_wr_en,
    output logic [XLEN-1:0]   ccs_wr_data,
    output logic              busy,
    output logic              done
);
    localparam int WORD_SHIFT = 2;

    seq_regs_t        r_q, r_d;
    logic             arb_take;
    entry_src_e       arb_src;
    logic [VEC_W-1:0] arb_vec;
    logic [XLEN-1:0]  stacked;

    exc_req_arbiter #(
        .TRAP_W (TRAP_W),
        .IRQ_W  (IRQ_W),
        .VEC_W  (VEC_W)
    ) u_arb (
        .brk_req    (brk_req),
        .brk_trap   (brk_trap),
        .miss_req   (miss_req),
        .irq_pend   (irq_pend),
        .irq_enable (ccs_i[IEN_BIT]),
        .take       (arb_take),
        .src        (arb_src),
        .vec_num    (arb_vec)
    );

    exc_status_stack #(.W(XLEN), .KEEP(2), .SHIFT(10)) u_stack (
        .old_status (ccs_i),
        .new_status (stacked)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (arb_take) begin
                    r_d.state    = ST_VREAD;
                    r_d.vec_addr = ebp_i + (XLEN'(arb_vec) << WORD_SHIFT);
                    r_d.ret_addr = (arb_src == SRC_BREAK) ? pc_i + XLEN'(BRK_ILEN) : pc_i;
                    r_d.status   = stacked;
                end
            end
            ST_VREAD: begin
                if (mem_rd_valid) begin
                    r_d.handler = mem_rd_data;
                    r_d.state   = ST_COMMIT;
                end
            end
            ST_COMMIT: r_d.state = ST_IDLE;
            default:   r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.state != ST_IDLE);
    assign mem_rd_req  = (r_q.state == ST_VREAD);
    assign mem_rd_addr = r_q.vec_addr;
    assign done        = (r_q.state == ST_COMMIT);
    assign pc_wr_en    = done;
    assign erp_wr_en   = done;
    assign ccs_wr_en   = done;
    assign pc_wr_data  = r_q.handler;
    assign erp_wr_data = r_q.ret_addr;
    assign ccs_wr_data = r_q.status;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_rd_req,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rd_valid,
    input logic        pc_wr_en,
    input logic        erp_wr_en,
    input logic        ccs_wr_en,
    input logic [31:0] ccs_wr_data,
    input logic        busy,
    input logic        done
);
    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R8
    commit_after_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && mem_rd_valid) |=> done);

    // R8
    strobes_together_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (pc_wr_en && erp_wr_en && ccs_wr_en));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R10
    read_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> busy);

    // R7
    stack_low_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ccs_wr_en |-> (ccs_wr_data[9:0] == 10'd0));
endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .pc_wr_en     (pc_wr_en),
    .erp_wr_en    (erp_wr_en),
    .ccs_wr_en    (ccs_wr_en),
    .ccs_wr_data  (ccs_wr_data),
    .busy         (busy),
    .done         (done)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic        brk_req, miss_req, mem_rd_valid;
    logic [7:0]  brk_trap;
    logic [31:0] irq_pend, pc_i, ebp_i, ccs_i, mem_rd_data;
    logic        mem_rd_req, pc_wr_en, erp_wr_en, ccs_wr_en, busy, done;
    logic [31:0] mem_rd_addr, pc_wr_data, erp_wr_data, ccs_wr_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_seq u_dut (
        .clk(clk), .rst(rst), .brk_req(brk_req), .brk_trap(brk_trap),
        .miss_req(miss_req), .irq_pend(irq_pend), .pc_i(pc_i), .ebp_i(ebp_i),
        .ccs_i(ccs_i), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data), .erp_wr_en(erp_wr_en),
        .erp_wr_data(erp_wr_data), .ccs_wr_en(ccs_wr_en),
        .ccs_wr_data(ccs_wr_data), .busy(busy), .done(done)
    );

    function automatic int msb_of(input logic [31:0] m);
        int r = -1;
        for (int i = 0; i < 32; i++) if (m[i]) r = i;
        return r;
    endfunction

    function automatic logic [31:0] push_ccs(input logic [31:0] old);
        logic [31:0] sh;
        sh = old << 12;
        return (old & 32'hC000_0000) | (sh >> 2);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        brk_req = 0; miss_req = 0; irq_pend = '0; mem_rd_valid = 0;
    endtask

    // Runs one accepted entry; requests are dropped after the accepting edge.
    task automatic run_entry(input string req, input logic [31:0] exp_addr,
                             input logic [31:0] exp_ret, input logic [31:0] exp_ccs,
                             input int lat, input logic [31:0] handler);
        @(posedge clk);
        @(negedge clk);
        brk_req = 0; miss_req = 0; irq_pend = '0;
        check(mem_rd_req === 1'b1, {req, " R9 read issued"}, {31'd0, mem_rd_req}, 32'd1);
        check(mem_rd_addr === exp_addr, {req, " vector address"}, mem_rd_addr, exp_addr);
        for (int k = 0; k < lat; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(mem_rd_req === 1'b1 && mem_rd_addr === exp_addr && !done,
                  "R9 read held while waiting", mem_rd_addr, exp_addr);
        end
        mem_rd_valid = 1; mem_rd_data = handler;
        @(posedge clk);
        @(negedge clk);
        mem_rd_valid = 0;
        check(done === 1'b1 && pc_wr_en === 1'b1 && erp_wr_en === 1'b1 && ccs_wr_en === 1'b1,
              "R8 commit strobes", {28'd0, done, pc_wr_en, erp_wr_en, ccs_wr_en}, 32'hF);
        check(pc_wr_data === handler, "R8 new pc", pc_wr_data, handler);
        check(erp_wr_data === exp_ret, {req, " return address"}, erp_wr_data, exp_ret);
        check(ccs_wr_data === exp_ccs, "R7 status push", ccs_wr_data, exp_ccs);
        @(posedge clk);
        @(negedge clk);
        check(!done && !pc_wr_en, "R8 done single cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic expect_quiet(input string req, input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(!busy && !mem_rd_req && !pc_wr_en && !erp_wr_en && !ccs_wr_en,
                  req, {30'd0, busy, mem_rd_req}, 32'd0);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd1234;
        void'($urandom(seed));
        idle_inputs();
        brk_trap = 0; pc_i = 32'h0000_1000; ebp_i = 32'h8000_0000;
        ccs_i = 32'h0000_0020; mem_rd_data = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy && !done && !mem_rd_req && !pc_wr_en && !erp_wr_en && !ccs_wr_en,
              "R1 reset state", {26'd0, busy, done, mem_rd_req, pc_wr_en, erp_wr_en, ccs_wr_en}, 32'd0);
        rst = 0;
        @(negedge clk);

        // R2 break: trap 0x0B, return PC+2
        brk_req = 1; brk_trap = 8'h0B; ccs_i = 32'hC000_03FF;
        run_entry("R2", 32'h8000_002C, 32'h0000_1002, 32'hC00F_FC00, 2, 32'h4000_0100);

        // R3 miss: vector 4
        miss_req = 1; pc_i = 32'h0000_2468; ccs_i = 32'h4001_2345;
        run_entry("R3", 32'h8000_0010, 32'h0000_2468, push_ccs(32'h4001_2345), 0, 32'h4000_0200);

        // R4 interrupt, lowest / middle / highest line
        ccs_i = 32'h0000_0020; irq_pend = 32'h0000_0001;
        run_entry("R4 line0", 32'h8000_00C0, 32'h0000_2468, 32'h0000_8000, 1, 32'h11);
        ccs_i = 32'h8000_0021; irq_pend = 32'h0000_0201;
        run_entry("R4 line9", 32'h8000_00E4, 32'h0000_2468, push_ccs(32'h8000_0021), 0, 32'h22);
        ccs_i = 32'hFFFF_FFFF; irq_pend = 32'h8000_0001;
        run_entry("R4 line31", 32'h8000_013C, 32'h0000_2468, 32'hFFFF_FC00, 3, 32'h33);

        // R5 ignored: enable clear, then empty mask
        ccs_i = 32'hFFFF_FFDF; irq_pend = 32'hFFFF_FFFF;
        expect_quiet("R5 irq with enable clear", 3);
        ccs_i = 32'h0000_0020; irq_pend = '0;
        expect_quiet("R5 empty mask", 2);
        irq_pend = '0;

        // R6 priority
        brk_req = 1; brk_trap = 8'h03; miss_req = 1; irq_pend = 32'h10;
        run_entry("R6 break over all", 32'h8000_000C, 32'h0000_246A, push_ccs(32'h20), 0, 32'h44);
        miss_req = 1; irq_pend = 32'h10;
        run_entry("R6 miss over irq", 32'h8000_0010, 32'h0000_2468, push_ccs(32'h20), 0, 32'h55);

        // R10 request held during a busy entry waits
        brk_req = 1; brk_trap = 8'h07;
        @(posedge clk);
        @(negedge clk);
        brk_req = 0; miss_req = 1;
        check(mem_rd_addr === 32'h8000_001C, "R10 first entry address", mem_rd_addr, 32'h8000_001C);
        repeat (2) begin
            @(posedge clk);
            @(negedge clk);
            check(mem_rd_addr === 32'h8000_001C, "R10 no preemption while busy", mem_rd_addr, 32'h8000_001C);
        end
        mem_rd_valid = 1; mem_rd_data = 32'h66;
        @(posedge clk);
        @(negedge clk);
        mem_rd_valid = 0;
        check(done === 1'b1 && pc_wr_data === 32'h66, "R10 first commit", pc_wr_data, 32'h66);
        @(posedge clk);
        @(negedge clk);
        check(busy === 1'b0, "R10 idle after commit", {31'd0, busy}, 32'd0);
        run_entry("R10 waiting miss", 32'h8000_0010, 32'h0000_2468, push_ccs(32'h20), 0, 32'h77);

        // Random mix
        for (int it = 0; it < 60; it++) begin
            logic b, m;
            logic [31:0] ip, c, p, e, h, addr, ret;
            int vn, lat;
            bit take;
            b  = ($urandom % 4) == 0;
            m  = ($urandom % 3) == 0;
            ip = ($urandom % 2) ? $urandom : ($urandom % 2 ? 32'd0 : (32'd1 << ($urandom % 32)));
            c  = $urandom; p = $urandom & 32'hFFFF_FFFE; e = $urandom & 32'hFFFF_F000;
            h  = $urandom; lat = $urandom % 4;
            brk_trap = 8'($urandom);
            take = 1; ret = p;
            if (b) begin vn = brk_trap; ret = p + 2; end
            else if (m) vn = 4;
            else if (ip != 0 && c[5]) vn = msb_of(ip) + 32'h30;
            else take = 0;
            addr = e + 32'(vn) * 4;
            pc_i = p; ebp_i = e; ccs_i = c;
            brk_req = b; miss_req = m; irq_pend = ip;
            if (take) run_entry("R2/R3/R4 random", addr, ret, push_ccs(c), lat, h);
            else begin
                expect_quiet("R5 random ignored", 1);
                idle_inputs();
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule